// File: doc/BRIEF.md
# Majority-Vote Comparator Glitch Filter

This block cleans up two single-bit comparator outputs, a low channel and a high channel, before they reach trip logic. Each channel samples its input at a programmable rate, keeps a history of up to 32 samples, and counts how many samples in a programmable window disagree with the current filtered level. The filtered bit changes only when that count reaches a programmable vote threshold. Narrow glitches are therefore rejected, and a real transition passes through with a bounded, known delay.

Each channel has its own window, threshold, prescale and history-initialize control. All of them are set through a small synchronous register write port, and a combinational read port returns the stored settings. A sticky lock bit, once set, freezes the filter settings of both channels until the next reset.

Top module: `cmp_vote_filter`

## Requirements
- R1: After reset both filtered outputs are 0, every sample history is 0, all settings are 0, the lock is clear and every readable address returns 0.
- R2: A channel with prescale value P takes one sample every P+1 clock cycles. Its sample counter restarts from zero when an initialize is written, and no sample is taken in that cycle.
- R3: Only the newest W+1 samples are counted, where W is the window field in bits [4:0] of the channel control register, so W=0 uses one sample and W=31 uses 32 samples.
- R4: With threshold field T in control bits [12:8], on a sample a 0 output becomes 1 if at least T+1 ones are in the window (new sample included), and a 1 output becomes 0 if at least T+1 zeros are in it. Otherwise the output holds. It changes only in the cycle after a sample.
- R5: Writing a control word with bit 15 set loads all 32 history entries with the channel's present input and leaves the output unchanged. Bit 15 always reads back as 0.
- R6: Writing 1 to bit 0 at address 4 sets the lock, and writing 0 there has no effect. While the lock is set, writes to the control and prescale addresses of both channels are ignored, initialize included. Only reset clears the lock.
- R7: The channels are independent. The low channel uses control address 0 and prescale address 1, the high channel uses control address 2 and prescale address 3, and each address affects only its own channel.
- R8: The read port returns, without delay, the control word (window in [4:0], threshold in [12:8], other bits 0), the prescale value, or the lock in bit 0 for the addressed register, and 0 for unused addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data |
| cmp_lo_i | input | 1 | Low channel comparator input |
| cmp_hi_i | input | 1 | High channel comparator input |
| filt_lo_o | output | 1 | Low channel filtered output |
| filt_hi_o | output | 1 | High channel filtered output |

## Verification
The first test drives single-cycle pulses into a five-sample window with a three-vote threshold. The output must stay low, which separates real voting from pass-through. Steady level steps then confirm that a flip lands exactly on the sample that reaches the threshold. Pseudo-random toggling at several densities, with nonzero prescales and different settings per channel, shows whether the sample spacing is right and whether the channels stay independent. The extreme windows of one and 32 samples, and an initialize that preloads a full opposite history, cover the edges of the window mask and the preload path.

// File: rtl/cvf_pkg.sv
package cvf_pkg;
  localparam int unsigned HIST_W  = 32;
  localparam int unsigned FLD_W   = 5;
  localparam int unsigned PRE_W   = 16;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned NCH     = 2;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CNT_W   = $clog2(HIST_W + 1);
  // control word layout
  localparam int unsigned WIN_LSB  = 0;
  localparam int unsigned THR_LSB  = 8;
  localparam int unsigned INIT_BIT = 15;
  localparam int unsigned LOCK_ADDR = 2 * NCH;
endpackage

// File: rtl/cvf_prescale.sv
module cvf_prescale
  import cvf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  // >= keeps a shrinking prescale from running the counter around
  assign tick_o = (cnt_q >= presc_i) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  a_r2_wrap_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  a_r2_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !restart_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cvf_vote.sv
module cvf_vote
  import cvf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  input  logic             tick_i,
  input  logic             init_i,
  input  logic [FLD_W-1:0] win_i,
  input  logic [FLD_W-1:0] thr_i,
  output logic             filt_o
);
  logic [HIST_W-1:0] hist_q, hist_nxt;
  logic [CNT_W-1:0]  ones, zeros, need, span;
  logic              filt_nxt;

  assign hist_nxt = {hist_q[HIST_W-2:0], din_i};
  assign span     = CNT_W'(win_i) + 1'b1;
  assign need     = CNT_W'(thr_i) + 1'b1;

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_W; i++) begin
      if ((i <= int'(win_i)) && hist_nxt[i]) ones = ones + 1'b1;
    end
    zeros = span - ones;
  end

  always_comb begin
    filt_nxt = filt_o;
    if (!filt_o && (ones >= need))  filt_nxt = 1'b1;
    else if (filt_o && (zeros >= need)) filt_nxt = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      filt_o <= 1'b0;
    end else if (init_i) begin
      hist_q <= {HIST_W{din_i}};
    end else if (tick_i) begin
      hist_q <= hist_nxt;
      filt_o <= filt_nxt;
    end
  end

  a_r4_hold_between_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i || init_i) |=> $stable(filt_o));
  a_r5_init_fills_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (hist_q == {HIST_W{$past(din_i)}}));
  a_r3_shift_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !init_i) |=> (hist_q[0] == $past(din_i)));
endmodule

// File: rtl/cvf_regs.sv
module cvf_regs
  import cvf_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic [NCH-1:0][FLD_W-1:0] win_o,
  output logic [NCH-1:0][FLD_W-1:0] thr_o,
  output logic [NCH-1:0][PRE_W-1:0] presc_o,
  output logic [NCH-1:0]            init_o
);
  logic lock_q;
  logic wr_ok;

  assign wr_ok = wr_en_i && !lock_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * ch);
    localparam logic [ADDR_W-1:0] PRE_A  = ADDR_W'(2 * ch + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        win_o[ch]   <= '0;
        thr_o[ch]   <= '0;
        presc_o[ch] <= '0;
      end else if (wr_ok) begin
        if (wr_addr_i == CTRL_A) begin
          win_o[ch] <= wr_data_i[WIN_LSB +: FLD_W];
          thr_o[ch] <= wr_data_i[THR_LSB +: FLD_W];
        end
        if (wr_addr_i == PRE_A) presc_o[ch] <= wr_data_i[PRE_W-1:0];
      end
    end

    assign init_o[ch] = wr_ok && (wr_addr_i == CTRL_A) && wr_data_i[INIT_BIT];

    a_r6_frozen_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> ($stable(win_o[ch]) && $stable(thr_o[ch]) && $stable(presc_o[ch])));
    a_r6_no_init_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |-> !init_o[ch]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (wr_en_i && (wr_addr_i == ADDR_W'(LOCK_ADDR)) && wr_data_i[0]) lock_q <= 1'b1;
  end

  always_comb begin
    rd_data_o = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (rd_addr_i == ADDR_W'(2 * ch)) begin
        rd_data_o[WIN_LSB +: FLD_W] = win_o[ch];
        rd_data_o[THR_LSB +: FLD_W] = thr_o[ch];
      end
      if (rd_addr_i == ADDR_W'(2 * ch + 1)) rd_data_o[PRE_W-1:0] = presc_o[ch];
    end
    if (rd_addr_i == ADDR_W'(LOCK_ADDR)) rd_data_o[0] = lock_q;
  end

  a_r6_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
endmodule

// File: rtl/cmp_vote_filter.sv
module cmp_vote_filter
  import cvf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cmp_lo_i,
  input  logic              cmp_hi_i,
  output logic              filt_lo_o,
  output logic              filt_hi_o
);
  logic [NCH-1:0][FLD_W-1:0] win, thr;
  logic [NCH-1:0][PRE_W-1:0] presc;
  logic [NCH-1:0]            init, tick, din, filt;

  assign din       = {cmp_hi_i, cmp_lo_i};
  assign filt_lo_o = filt[0];
  assign filt_hi_o = filt[1];

  cvf_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .win_o     (win),
    .thr_o     (thr),
    .presc_o   (presc),
    .init_o    (init)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    cvf_prescale i_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .presc_i   (presc[ch]),
      .restart_i (init[ch]),
      .tick_o    (tick[ch])
    );

    cvf_vote i_vote (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (din[ch]),
      .tick_i (tick[ch]),
      .init_i (init[ch]),
      .win_i  (win[ch]),
      .thr_i  (thr[ch]),
      .filt_o (filt[ch])
    );
  end
endmodule

// File: tb/test_cmp_vote_filter.sv
module test_cmp_vote_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cmp_lo = 1'b0, cmp_hi = 1'b0;
  logic        filt_lo, filt_hi;

  int checks = 0, errors = 0;
  bit running = 1'b0;
  string out_tag = "R4";

  always #5 clk = ~clk;

  cmp_vote_filter i_cmp_vote_filter (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cmp_lo_i(cmp_lo), .cmp_hi_i(cmp_hi), .filt_lo_o(filt_lo), .filt_hi_o(filt_hi)
  );

  // behavioural reference
  int m_cnt[2], m_win[2], m_thr[2], m_pre[2];
  bit m_hist[2][32];
  bit m_out[2];
  bit m_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_win[c] = 0; m_thr[c] = 0; m_pre[c] = 0; m_out[c] = 0;
        for (int i = 0; i < 32; i++) m_hist[c][i] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit d;
        bit ini;
        d = (c == 0) ? cmp_lo : cmp_hi;
        ini = wr_en && !m_lock && (wr_addr == 3'(2*c)) && wr_data[15];
        if (ini) begin
          m_cnt[c] = 0;
          for (int i = 0; i < 32; i++) m_hist[c][i] = d;
        end else if (m_cnt[c] >= m_pre[c]) begin
          int ones;
          m_cnt[c] = 0;
          for (int i = 31; i > 0; i--) m_hist[c][i] = m_hist[c][i-1];
          m_hist[c][0] = d;
          ones = 0;
          for (int i = 0; i <= m_win[c]; i++) ones += m_hist[c][i];
          if (!m_out[c] && ones >= m_thr[c] + 1) m_out[c] = 1;
          else if (m_out[c] && (m_win[c] + 1 - ones) >= m_thr[c] + 1) m_out[c] = 0;
        end else m_cnt[c]++;
      end
      if (wr_en && !m_lock) begin
        for (int c = 0; c < 2; c++) begin
          if (wr_addr == 3'(2*c)) begin m_win[c] = wr_data[4:0]; m_thr[c] = wr_data[12:8]; end
          if (wr_addr == 3'(2*c+1)) m_pre[c] = wr_data;
        end
      end
      if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_lock = 1;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return 16'((m_thr[0] << 8) | m_win[0]);
      3'd1: return 16'(m_pre[0]);
      3'd2: return 16'((m_thr[1] << 8) | m_win[1]);
      3'd3: return 16'(m_pre[1]);
      3'd4: return 16'(m_lock);
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk({out_tag, " lo"}, 16'(filt_lo), 16'(m_out[0]));
      chk({out_tag, " hi R7"}, 16'(filt_hi), 16'(m_out[1]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    @(negedge clk);
    rd_addr = a;
    #2 chk(tag, rd_data, exp_rd(a));
  endtask

  task automatic drive(input int n, input int dens_lo, input int dens_hi);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp_lo = ($urandom_range(99) < dens_lo);
      cmp_hi = ($urandom_range(99) < dens_hi);
    end
  endtask

  task automatic hold(input int n, input bit lo, input bit hi);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cmp_lo = lo; cmp_hi = hi;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 filt_lo", 16'(filt_lo), 16'h0);
    chk("R1 filt_hi", 16'(filt_hi), 16'h0);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1 chk("R1 read", rd_data, 16'h0);
    end
    rst_n = 1;
    running = 1;

    // R4 glitch rejection: window 5, threshold 3
    out_tag = "R4";
    wr(3'd0, 16'h0204);
    wr(3'd2, 16'h0204);
    rd("R8 ctrl lo", 3'd0);
    for (int k = 0; k < 6; k++) begin
      hold(1, 1, 1); hold(4, 0, 0);
    end
    chk("R4 glitch rejected", 16'(filt_lo), 16'h0);
    hold(2, 1, 1);
    hold(1, 1, 1);
    @(negedge clk);
    chk("R4 flip at third one", 16'(filt_lo), 16'h1);
    hold(1, 0, 0); hold(1, 1, 1); hold(1, 0, 0); hold(6, 1, 1);
    chk("R4 held high", 16'(filt_hi), 16'h1);
    hold(8, 0, 0);
    chk("R4 back low", 16'(filt_lo), 16'h0);

    // R2 R7 prescale and independent settings
    out_tag = "R2";
    wr(3'd1, 16'd3);
    wr(3'd3, 16'd6);
    wr(3'd2, 16'h0306);
    rd("R8 pre lo R7", 3'd1);
    rd("R8 pre hi R7", 3'd3);
    drive(600, 50, 50);
    drive(400, 80, 20);
    drive(400, 20, 80);

    // R3 window extremes
    out_tag = "R3";
    wr(3'd1, 16'd0); wr(3'd3, 16'd1);
    wr(3'd0, 16'h0000);          // one sample, one vote: follows input
    wr(3'd2, 16'h0F1F);          // 32 samples, 16 votes
    drive(300, 50, 60);
    hold(3, 1, 1);
    chk("R3 single sample follows", 16'(filt_lo), 16'h1);
    hold(1, 0, 0); @(negedge clk);
    chk("R3 single sample follows low", 16'(filt_lo), 16'h0);
    drive(300, 30, 70);
    wr(3'd0, 16'h0A1F); wr(3'd2, 16'h0004);
    drive(300, 40, 40);

    // R5 initialize preload
    out_tag = "R5";
    wr(3'd1, 16'd4);
    wr(3'd0, 16'h041F);
    hold(40, 0, 0);
    @(negedge clk); cmp_lo = 1;
    wr(3'd0, 16'h841F);
    rd("R5 init reads 0", 3'd0);
    hold(12, 1, 0);
    chk("R5 preload flips", 16'(filt_lo), 16'h1);
    drive(200, 50, 50);
    wr(3'd2, 16'h8102);
    drive(200, 60, 40);

    // R6 lock
    out_tag = "R6";
    wr(3'd4, 16'h0000);
    rd("R6 zero no effect", 3'd4);
    wr(3'd0, 16'h0101);
    wr(3'd4, 16'h0001);
    rd("R6 lock set", 3'd4);
    wr(3'd0, 16'h0A05);
    wr(3'd1, 16'd9);
    wr(3'd3, 16'd9);
    wr(3'd2, 16'h8000);
    rd("R6 ctrl lo frozen", 3'd0);
    rd("R6 pre lo frozen", 3'd1);
    rd("R6 ctrl hi frozen", 3'd2);
    rd("R6 pre hi frozen", 3'd3);
    rd("R8 unused addr", 3'd6);
    wr(3'd4, 16'h0000);
    rd("R6 lock sticky", 3'd4);
    drive(300, 50, 50);

    running = 0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule